// File: doc/BRIEF.md
# CEC Bit-Timing Receiver

This block watches a single open-drain consumer-electronics-control line and turns its pulses into received bytes. The line is resynchronised into the core clock domain, then a slow tick (nominally 32768 Hz) paces two counters. One counter measures how long the line stays low and the other measures how long it stays high before the next falling edge. Each completed pulse is judged against programmable tick-count windows. The result is one of five kinds: a start bit, a logic one, a logic zero, an over-long low, or a malformed pulse.

A frame begins with a start bit. Each block that follows carries ten data-bit pulses: eight payload bits sent most significant first, then an end-of-message bit, then the acknowledge bit. When the tenth bit arrives, a one-cycle strobe presents the byte together with its end-of-message and acknowledge values. Timing faults raise a one-cycle error pulse and throw away the partial frame. The block does not buffer messages, filter addresses or drive the acknowledge slot. All window thresholds are input ports, so a register bank elsewhere can tune them.

Top module: `cec_bit_receiver`

## Requirements
- R1: After reset, start_det, byte_valid and frame_err are 0, and a line held high produces none of them.
- R2: A pulse is a start bit when its low count, its high count and their sum each fall inside the matching start window (inclusive bounds), and its high phase did not time out. A start bit gives a one-cycle start_det pulse and opens a frame.
- R3: A pulse whose low count lies in the one-window is a 1, and one whose low count lies in the zero-window is a 0. In both cases low plus high must be at least bit_tot_min, unless the high phase timed out.
- R4: Inside a frame, data bits are gathered in groups of ten. The first eight form byte_data, most significant bit first. The ninth is byte_eom and the tenth is byte_ack. byte_valid pulses for one cycle as the tenth bit is accepted.
- R5: A byte with byte_eom = 0 keeps the frame open, so the next ten bits form another byte without a new start bit. A byte with byte_eom = 1 closes the frame, and later data bits produce no output until a start bit.
- R6: A pulse whose low count exceeds err_low_th and is not inside the start low window raises frame_err and closes any frame, whether or not a frame was open.
- R7: Inside a frame, a pulse that is neither a start bit nor a data bit raises frame_err and discards the partial byte. Outside a frame, such a pulse produces no output.
- R8: A start bit that arrives in the middle of a byte restarts the frame, and the bits gathered before it are dropped.
- R9: A high phase longer than bit_high_max ticks ends the current pulse without waiting for a falling edge. Such a pulse can never be a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timing tick enable |
| cec_in | input | 1 | Raw, asynchronous line level |
| start_low_min | input | CNT_W | Start bit low phase, lower bound |
| start_low_max | input | CNT_W | Start bit low phase, upper bound |
| start_high_min | input | CNT_W | Start bit high phase, lower bound |
| start_high_max | input | CNT_W | Start bit high phase, upper bound |
| start_tot_min | input | CNT_W | Start bit period, lower bound |
| start_tot_max | input | CNT_W | Start bit period, upper bound |
| one_low_min | input | CNT_W | Logic one low phase, lower bound |
| one_low_max | input | CNT_W | Logic one low phase, upper bound |
| zero_low_min | input | CNT_W | Logic zero low phase, lower bound |
| zero_low_max | input | CNT_W | Logic zero low phase, upper bound |
| bit_tot_min | input | CNT_W | Minimum data bit period |
| bit_high_max | input | CNT_W | Longest high phase before a pulse ends |
| err_low_th | input | CNT_W | Low count above which a low is an error |
| start_det | output | 1 | Start bit seen (one cycle) |
| byte_valid | output | 1 | Byte completed (one cycle) |
| byte_data | output | DATA_W | Received payload byte |
| byte_eom | output | 1 | End-of-message bit of the byte |
| byte_ack | output | 1 | Acknowledge bit of the byte |
| frame_err | output | 1 | Timing error (one cycle) |

## Verification
The assertions assume that the threshold ports hold steady while pulses are being measured. They also assume that tick arrives as isolated one-cycle pulses spaced wider than the synchroniser depth, so each line edge settles before the next tick is counted. The bench meets both assumptions. It drives constant thresholds, raises tick once every four clocks, and moves the line only on the falling clock edge that follows a ticked cycle. As a result, every phase spans an exact number of ticks, and the reference model can classify each pulse from those integer counts.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

   typedef enum logic [2:0] {
      PK_BAD,
      PK_START,
      PK_ONE,
      PK_ZERO,
      PK_ERRLOW
   } pulse_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LOW,
      PH_HIGH
   } phase_e;

endpackage

// File: rtl/cec_rx_sync.sv
module cec_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic fall_o,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cec_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign level_o = chain[STAGES-1];
   assign fall_o  = prev & ~chain[STAGES-1];
   assign rise_o  = ~prev & chain[STAGES-1];

endmodule

// File: rtl/cec_rx_phase_meter.sv
module cec_rx_phase_meter
   import cec_rx_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             fall,
   input  logic             rise,
   input  logic [CNT_W-1:0] high_limit,
   output logic             pulse_vld,
   output logic [CNT_W-1:0] pulse_low,
   output logic [CNT_W-1:0] pulse_high,
   output logic             pulse_to
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 6) begin : g_bad_width
         $error("cec_rx_phase_meter: CNT_W too small for tick windows");
      end
   endgenerate

   phase_e           phase;
   logic [CNT_W-1:0] low_cnt;
   logic [CNT_W-1:0] low_q;
   logic [CNT_W-1:0] high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         low_cnt    <= '0;
         low_q      <= '0;
         high_cnt   <= '0;
         pulse_vld  <= 1'b0;
         pulse_low  <= '0;
         pulse_high <= '0;
         pulse_to   <= 1'b0;
      end else begin
         pulse_vld <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (fall) begin
                  low_cnt <= '0;
                  phase   <= PH_LOW;
               end
            end
            PH_LOW: begin
               if (rise) begin
                  low_q    <= low_cnt;
                  high_cnt <= '0;
                  phase    <= PH_HIGH;
               end else if (tick && low_cnt != CNT_MAX) begin
                  low_cnt <= low_cnt + 1'b1;
               end
            end
            PH_HIGH: begin
               if (fall) begin
                  pulse_vld  <= 1'b1;
                  pulse_low  <= low_q;
                  pulse_high <= high_cnt;
                  pulse_to   <= 1'b0;
                  low_cnt    <= '0;
                  phase      <= PH_LOW;
               end else if (tick) begin
                  if (high_cnt >= high_limit) begin
                     pulse_vld  <= 1'b1;
                     pulse_low  <= low_q;
                     pulse_high <= high_cnt;
                     pulse_to   <= 1'b1;
                     phase      <= PH_IDLE;
                  end else begin
                     high_cnt <= high_cnt + 1'b1;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // A pulse never reports two cycles in a row.
   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_vld |=> !pulse_vld);

   // A pulse closed by an edge never has a high phase beyond the limit.
   assert_high_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_vld && !pulse_to) |-> (pulse_high <= high_limit));

   // While low, the low count never wraps.
   assert_low_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW && $past(phase) == PH_LOW && !$past(fall)) |->
         (low_cnt >= $past(low_cnt)));

endmodule

// File: rtl/cec_rx_classify.sv
module cec_rx_classify
   import cec_rx_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic [CNT_W-1:0] low,
   input  logic [CNT_W-1:0] high,
   input  logic             timed_out,
   input  logic [CNT_W-1:0] start_low_min,
   input  logic [CNT_W-1:0] start_low_max,
   input  logic [CNT_W-1:0] start_high_min,
   input  logic [CNT_W-1:0] start_high_max,
   input  logic [CNT_W-1:0] start_tot_min,
   input  logic [CNT_W-1:0] start_tot_max,
   input  logic [CNT_W-1:0] one_low_min,
   input  logic [CNT_W-1:0] one_low_max,
   input  logic [CNT_W-1:0] zero_low_min,
   input  logic [CNT_W-1:0] zero_low_max,
   input  logic [CNT_W-1:0] bit_tot_min,
   input  logic [CNT_W-1:0] err_low_th,
   output pulse_kind_e      kind
);

   localparam int SUM_W = CNT_W + 1;

   logic [SUM_W-1:0] total;
   logic start_low_ok, start_high_ok, start_tot_ok;
   logic one_low_ok, zero_low_ok, period_ok, long_low;

   assign total = {1'b0, low} + {1'b0, high};

   assign start_low_ok  = (low >= start_low_min) && (low <= start_low_max);
   assign start_high_ok = (high >= start_high_min) && (high <= start_high_max);
   assign start_tot_ok  = (total >= {1'b0, start_tot_min}) &&
                          (total <= {1'b0, start_tot_max});
   assign one_low_ok    = (low >= one_low_min) && (low <= one_low_max);
   assign zero_low_ok   = (low >= zero_low_min) && (low <= zero_low_max);
   assign period_ok     = timed_out || (total >= {1'b0, bit_tot_min});
   assign long_low      = (low > err_low_th) && !start_low_ok;

   always_comb begin
      if (long_low)
         kind = PK_ERRLOW;
      else if (!timed_out && start_low_ok && start_high_ok && start_tot_ok)
         kind = PK_START;
      else if (one_low_ok && period_ok)
         kind = PK_ONE;
      else if (zero_low_ok && period_ok)
         kind = PK_ZERO;
      else
         kind = PK_BAD;
   end

endmodule

// File: rtl/cec_bit_receiver.sv
module cec_bit_receiver
   import cec_rx_pkg::*;
#(
   parameter int CNT_W       = 10,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cec_in,
   input  logic [CNT_W-1:0]  start_low_min,
   input  logic [CNT_W-1:0]  start_low_max,
   input  logic [CNT_W-1:0]  start_high_min,
   input  logic [CNT_W-1:0]  start_high_max,
   input  logic [CNT_W-1:0]  start_tot_min,
   input  logic [CNT_W-1:0]  start_tot_max,
   input  logic [CNT_W-1:0]  one_low_min,
   input  logic [CNT_W-1:0]  one_low_max,
   input  logic [CNT_W-1:0]  zero_low_min,
   input  logic [CNT_W-1:0]  zero_low_max,
   input  logic [CNT_W-1:0]  bit_tot_min,
   input  logic [CNT_W-1:0]  bit_high_max,
   input  logic [CNT_W-1:0]  err_low_th,
   output logic              start_det,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data,
   output logic              byte_eom,
   output logic              byte_ack,
   output logic              frame_err
);

   localparam int BITS_PER_BLOCK = DATA_W + 2;
   localparam int IDX_W = $clog2(BITS_PER_BLOCK);
   localparam logic [IDX_W-1:0] IDX_EOM = IDX_W'(DATA_W);
   localparam logic [IDX_W-1:0] IDX_ACK = IDX_W'(DATA_W + 1);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("cec_bit_receiver: DATA_W must be at least 2");
      end
   endgenerate

   logic level, fall, rise;
   logic             pulse_vld, pulse_to;
   logic [CNT_W-1:0] pulse_low, pulse_high;
   pulse_kind_e      kind;

   cec_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (cec_in),
      .level_o (level),
      .fall_o  (fall),
      .rise_o  (rise)
   );

   cec_rx_phase_meter #(.CNT_W(CNT_W)) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .fall       (fall),
      .rise       (rise),
      .high_limit (bit_high_max),
      .pulse_vld  (pulse_vld),
      .pulse_low  (pulse_low),
      .pulse_high (pulse_high),
      .pulse_to   (pulse_to)
   );

   cec_rx_classify #(.CNT_W(CNT_W)) u_classify (
      .low            (pulse_low),
      .high           (pulse_high),
      .timed_out      (pulse_to),
      .start_low_min  (start_low_min),
      .start_low_max  (start_low_max),
      .start_high_min (start_high_min),
      .start_high_max (start_high_max),
      .start_tot_min  (start_tot_min),
      .start_tot_max  (start_tot_max),
      .one_low_min    (one_low_min),
      .one_low_max    (one_low_max),
      .zero_low_min   (zero_low_min),
      .zero_low_max   (zero_low_max),
      .bit_tot_min    (bit_tot_min),
      .err_low_th     (err_low_th),
      .kind           (kind)
   );

   logic              in_frame;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] data_sr, data_next;
   logic              eom_q;
   logic              bit_val, is_data;
   logic              level_seen;

   assign is_data = (kind == PK_ONE) || (kind == PK_ZERO);
   assign bit_val = (kind == PK_ONE);

   generate
      if (MSB_FIRST) begin : g_msb
         assign data_next = {data_sr[DATA_W-2:0], bit_val};
      end else begin : g_lsb
         assign data_next = {bit_val, data_sr[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame   <= 1'b0;
         idx        <= '0;
         data_sr    <= '0;
         eom_q      <= 1'b0;
         start_det  <= 1'b0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
         byte_eom   <= 1'b0;
         byte_ack   <= 1'b0;
         frame_err  <= 1'b0;
      end else begin
         start_det  <= 1'b0;
         byte_valid <= 1'b0;
         frame_err  <= 1'b0;
         if (pulse_vld) begin
            if (kind == PK_ERRLOW) begin
               frame_err <= 1'b1;
               in_frame  <= 1'b0;
            end else if (kind == PK_START) begin
               start_det <= 1'b1;
               in_frame  <= 1'b1;
               idx       <= '0;
            end else if (in_frame) begin
               if (is_data) begin
                  if (idx < IDX_EOM) data_sr <= data_next;
                  if (idx == IDX_EOM) eom_q <= bit_val;
                  if (idx == IDX_ACK) begin
                     byte_valid <= 1'b1;
                     byte_data  <= data_sr;
                     byte_eom   <= eom_q;
                     byte_ack   <= bit_val;
                     idx        <= '0;
                     in_frame   <= !eom_q;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end else begin
                  frame_err <= 1'b1;
                  in_frame  <= 1'b0;
               end
            end
         end
      end
   end

   // The synchronised level is consumed only through the edge strobes.
   assign level_seen = level;

   // At most one event per cycle.
   assert_one_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_det, byte_valid, frame_err}));

   // Every event follows a completed pulse from the meter.
   assert_event_from_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || byte_valid || frame_err) |-> $past(pulse_vld));

   // An error always leaves the frame closed.
   assert_err_closes_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !in_frame);

   // A final byte closes the frame.
   assert_eom_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && byte_eom) |-> !in_frame);

   // No event while the line has stayed high since reset.
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (level_seen && $past(level_seen) && !$past(pulse_vld)) |->
         !(start_det || byte_valid || frame_err));

endmodule

// File: tb/cec_bit_receiver_test.sv
module cec_bit_receiver_test;

   localparam int CW = 10;
   localparam int SL_MIN = 115, SL_MAX = 128, SH_MIN = 20, SH_MAX = 33;
   localparam int ST_MIN = 141, ST_MAX = 154;
   localparam int O_MIN = 13, O_MAX = 26, Z_MIN = 43, Z_MAX = 56;
   localparam int BT_MIN = 67, BH_MAX = 92, EL_TH = 111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cec_in = 1'b1;
   logic [1:0] tdiv = 2'd0;
   logic tick;
   logic start_det, byte_valid, byte_eom, byte_ack, frame_err;
   logic [7:0] byte_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(negedge clk) tdiv <= tdiv + 2'd1;
   assign tick = (tdiv == 2'd0);

   cec_bit_receiver uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cec_in(cec_in),
      .start_low_min(CW'(SL_MIN)), .start_low_max(CW'(SL_MAX)),
      .start_high_min(CW'(SH_MIN)), .start_high_max(CW'(SH_MAX)),
      .start_tot_min(CW'(ST_MIN)), .start_tot_max(CW'(ST_MAX)),
      .one_low_min(CW'(O_MIN)), .one_low_max(CW'(O_MAX)),
      .zero_low_min(CW'(Z_MIN)), .zero_low_max(CW'(Z_MAX)),
      .bit_tot_min(CW'(BT_MIN)), .bit_high_max(CW'(BH_MAX)),
      .err_low_th(CW'(EL_TH)),
      .start_det(start_det), .byte_valid(byte_valid), .byte_data(byte_data),
      .byte_eom(byte_eom), .byte_ack(byte_ack), .frame_err(frame_err)
   );

   // Reference model: expected event codes in order.
   int    q_code[$];
   string q_tag[$];
   bit    m_in = 1'b0;
   int    m_idx = 0, m_data = 0, m_eom = 0;

   function automatic void push_ev(int code, string tag);
      q_code.push_back(code);
      q_tag.push_back(tag);
   endfunction

   function automatic bit inside_w(int v, int lo, int hi);
      return (v >= lo) && (v <= hi);
   endfunction

   // 0 bad, 1 start, 2 one, 3 zero, 4 long low
   function automatic int classify(int lo, int hi);
      bit to = (hi > BH_MAX);
      int tot = lo + hi;
      if (lo > EL_TH && !inside_w(lo, SL_MIN, SL_MAX)) return 4;
      if (!to && inside_w(lo, SL_MIN, SL_MAX) && inside_w(hi, SH_MIN, SH_MAX) &&
          inside_w(tot, ST_MIN, ST_MAX)) return 1;
      if (inside_w(lo, O_MIN, O_MAX) && (to || tot >= BT_MIN)) return 2;
      if (inside_w(lo, Z_MIN, Z_MAX) && (to || tot >= BT_MIN)) return 3;
      return 0;
   endfunction

   function automatic void model(int lo, int hi, string tag);
      int c = classify(lo, hi);
      int b;
      case (c)
         4: begin push_ev(2000, tag); m_in = 1'b0; end
         1: begin push_ev(1000, tag); m_in = 1'b1; m_idx = 0; end
         2, 3: begin
            if (m_in) begin
               b = (c == 2) ? 1 : 0;
               if (m_idx < 8) m_data = ((m_data << 1) | b) & 255;
               else if (m_idx == 8) m_eom = b;
               if (m_idx == 9) begin
                  push_ev(3000 + m_data + (m_eom << 8) + (b << 9), tag);
                  m_idx = 0;
                  m_in = (m_eom == 0);
               end else begin
                  m_idx++;
               end
            end
         end
         default: begin
            if (m_in) begin push_ev(2000, tag); m_in = 1'b0; end
         end
      endcase
   endfunction

   task automatic wait_ticks(int n);
      for (int i = 0; i < n; i++) begin
         do @(posedge clk); while (!tick);
      end
      @(negedge clk);
   endtask

   task automatic align();
      wait_ticks(1);
   endtask

   task automatic pulse(int lo, int hi, string tag);
      model(lo, hi, tag);
      cec_in = 1'b0;
      wait_ticks(lo);
      cec_in = 1'b1;
      wait_ticks(hi);
   endtask

   task automatic send_start(string tag);
      pulse(120, 26, tag);
   endtask

   task automatic send_bit(int b, bit last, string tag);
      if (b != 0) pulse(19, last ? 100 : 59, tag);
      else        pulse(49, last ? 100 : 29, tag);
   endtask

   task automatic send_byte(int d, int eom, int ack, bit last, string tag);
      for (int i = 7; i >= 0; i--) send_bit((d >> i) & 1, 1'b0, tag);
      send_bit(eom, 1'b0, tag);
      send_bit(ack, last, tag);
   endtask

   task automatic checkpoint(string tag);
      repeat (20) @(negedge clk);
      checks++;
      if (q_code.size() != 0) begin
         errors++;
         $display("FAIL %s: pending events %0d, expected 0 (next code %0d)",
                  tag, q_code.size(), q_code[0]);
         q_code.delete();
         q_tag.delete();
      end
      align();
   endtask

   // Compare outputs against the model on every clock.
   always @(negedge clk) begin
      int obs;
      if (rst_n && !done) begin
         obs = 0;
         if ((start_det + byte_valid + frame_err) > 1) begin
            checks++; errors++;
            $display("FAIL R4: simultaneous events s=%0b b=%0b e=%0b, expected one",
                     start_det, byte_valid, frame_err);
         end
         if (start_det) obs = 1000;
         else if (frame_err) obs = 2000;
         else if (byte_valid) obs = 3000 + byte_data + (byte_eom << 8) + (byte_ack << 9);
         if (obs != 0) begin
            checks++;
            if (q_code.size() == 0) begin
               errors++;
               $display("FAIL R5/R7/R9: unexpected event %0d, expected none", obs);
            end else begin
               if (obs != q_code[0]) begin
                  errors++;
                  $display("FAIL %s: event %0d, expected %0d", q_tag[0], obs, q_code[0]);
               end
               void'(q_code.pop_front());
               void'(q_tag.pop_front());
            end
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: run hung at %0d cycles, expected completion", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (start_det || byte_valid || frame_err) begin
         errors++;
         $display("FAIL R1: events s=%0b b=%0b e=%0b, expected 0",
                  start_det, byte_valid, frame_err);
      end
      wait_ticks(50);
      checkpoint("R1");

      // R2 R3 R4: a single final byte
      send_start("R2");
      send_byte(8'hA5, 1, 0, 1'b1, "R4");
      checkpoint("R3");

      // R5: two-byte message, then stray bits after the final byte
      send_start("R2");
      send_byte(8'h3C, 0, 1, 1'b0, "R5");
      send_byte(8'hC3, 1, 0, 1'b0, "R5");
      send_bit(1, 1'b0, "R5");
      send_bit(0, 1'b1, "R5");
      checkpoint("R5");

      // R6 + R7: long low in a frame, then stray bits are ignored
      send_start("R2");
      send_bit(1, 1'b0, "R4");
      send_bit(0, 1'b0, "R4");
      pulse(112, 30, "R6");
      send_bit(1, 1'b0, "R7");
      send_bit(1, 1'b1, "R7");
      checkpoint("R7");

      // R6: long low outside a frame
      pulse(112, 100, "R6");
      checkpoint("R6");

      // R7: low between the data windows inside a frame
      send_start("R2");
      send_bit(0, 1'b0, "R4");
      pulse(35, 40, "R7");
      send_bit(1, 1'b1, "R7");
      checkpoint("R7");

      // R3: period too short inside a frame
      send_start("R2");
      pulse(15, 20, "R3");
      send_bit(1, 1'b1, "R3");
      checkpoint("R3");

      // R8: start in the middle of a byte restarts the frame
      send_start("R2");
      for (int i = 0; i < 4; i++) send_bit(i & 1, 1'b0, "R8");
      send_start("R8");
      send_byte(8'h5A, 1, 1, 1'b1, "R8");
      checkpoint("R8");

      // R9: start-length low with a high phase too long is not a start
      pulse(120, 40, "R9");
      send_bit(1, 1'b1, "R9");
      pulse(120, 100, "R9");
      send_bit(0, 1'b1, "R9");
      checkpoint("R9");

      // R3: zero bit whose high phase times out still counts
      send_start("R2");
      send_byte(8'h81, 1, 0, 1'b1, "R3");
      checkpoint("R3");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule